// File: doc/BRIEF.md
# Triple-Replica Result Voter with Per-Replica Mismatch Flags

This block sits behind three identical copies of an arithmetic unit that receive the same operands. Each clock it compares the three results pairwise, decides whether they all match, whether exactly one replica stands apart from two that agree, or whether no two match at all. It then registers a single forwarded result together with one mismatch flag per replica, a summary error flag and a separate flag for the case with no majority. A downstream recovery controller uses the per-replica flags to decide which copy to repair.

The forwarded result is not a bit-by-bit vote. It is the whole word of one replica that is not flagged, chosen with a fixed preference for replica A, then B, then C. When no two replicas agree, the forwarded result keeps its previous value.

A small classifier state machine records what kind of cycle was last captured. States: `IDLE` (entered only by reset, nothing captured yet), `UNANIMOUS` (all three matched), `MASKED` (exactly one replica was outvoted) and `SPLIT` (no two matched). Transitions: on every clock edge out of reset, from any state, the machine moves to `UNANIMOUS`, `MASKED` or `SPLIT` according to the replica results present at that edge. It returns to `IDLE` only through reset.

Top module: `tmr_voter`

## Requirements
- R1: While reset is asserted (rst_n low), vote_q, all three mismatch flags, err_q and split_q are 0.
- R2: All outputs are registered. They reflect the replica results present at the latest rising clock edge and do not change between edges when the inputs change.
- R3: When all three replica results are equal, vote_q takes that value and all flags, err_q and split_q are 0.
- R4: When exactly two replica results are equal, vote_q takes their common value, and only the flag of the third replica is 1. Of the replicas that are not flagged, A is forwarded first, then B, then C.
- R5: The flag of a replica (odd_a_q for A, odd_b_q for B, odd_c_q for C) is 1 exactly when that replica's result differs from both other results.
- R6: When all three results differ pairwise, split_q is 1, all three flags are 1, and vote_q keeps its previous value, which is 0 if no majority has been seen since reset.
- R7: err_q is 1 exactly when at least one mismatch flag is 1.
- R8: split_q is 0 whenever at least two replica results are equal, and at most one flag is then 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rep_a | input | DATA_W | Result of replica A |
| rep_b | input | DATA_W | Result of replica B |
| rep_c | input | DATA_W | Result of replica C |
| vote_q | output | DATA_W | Forwarded result of an agreeing replica |
| odd_a_q | output | 1 | Replica A differs from both others |
| odd_b_q | output | 1 | Replica B differs from both others |
| odd_c_q | output | 1 | Replica C differs from both others |
| err_q | output | 1 | Some replica is outvoted or no majority exists |
| split_q | output | 1 | No two replica results agree |

## Verification
The voter is driven with four kinds of input triples: all equal, each replica in turn carrying the odd value, all three distinct, and fully random words. The all-equal and odd-one-out cases separate correct forwarding from a selector that picks the wrong replica or a flag that is tied to the wrong position. All-distinct triples, some of them right after reset and some after a valid majority, show whether the last good result is held or replaced by a replica's word. Changing the inputs between clock edges shows whether any output leaks through combinationally.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

    localparam int NREP = 3;

    typedef enum logic [1:0] {
        VS_IDLE      = 2'd0,
        VS_UNANIMOUS = 2'd1,
        VS_MASKED    = 2'd2,
        VS_SPLIT     = 2'd3
    } vote_state_e;

endpackage

// File: rtl/tmr_disagree.sv
module tmr_disagree
    import tmr_vote_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [NREP-1:0][DATA_W-1:0] reps,
    output logic [NREP-1:0]             odd,
    output logic                        none_agree
);

    // one comparator pair per replica: it is odd when it matches neither peer
    for (genvar i = 0; i < NREP; i++) begin : g_odd
        localparam int J = (i + 1) % NREP;
        localparam int K = (i + 2) % NREP;
        assign odd[i] = (reps[i] != reps[J]) && (reps[i] != reps[K]);
    end

    assign none_agree = (reps[0] != reps[1]) &&
                        (reps[1] != reps[2]) &&
                        (reps[0] != reps[2]);

endmodule

// File: rtl/tmr_pick.sv
module tmr_pick
    import tmr_vote_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [NREP-1:0][DATA_W-1:0] reps,
    input  logic [NREP-1:0]             odd,
    output logic [DATA_W-1:0]           pick
);

    // lowest-index replica that is not flagged wins
    always_comb begin
        pick = reps[NREP-1];
        for (int i = NREP - 2; i >= 0; i--) begin
            if (!odd[i]) begin
                pick = reps[i];
            end
        end
    end

endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
    import tmr_vote_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rep_a,
    input  logic [DATA_W-1:0] rep_b,
    input  logic [DATA_W-1:0] rep_c,
    output logic [DATA_W-1:0] vote_q,
    output logic              odd_a_q,
    output logic              odd_b_q,
    output logic              odd_c_q,
    output logic              err_q,
    output logic              split_q
);

    logic [NREP-1:0][DATA_W-1:0] reps;
    logic [NREP-1:0]             odd;
    logic                        none_agree;
    logic [DATA_W-1:0]           pick;
    vote_state_e                 st_q;
    vote_state_e                 st_d;

    assign reps[0] = rep_a;
    assign reps[1] = rep_b;
    assign reps[2] = rep_c;

    tmr_disagree #(.DATA_W(DATA_W)) u_disagree (
        .reps       (reps),
        .odd        (odd),
        .none_agree (none_agree)
    );

    tmr_pick #(.DATA_W(DATA_W)) u_pick (
        .reps (reps),
        .odd  (odd),
        .pick (pick)
    );

    // classification of the current triple
    always_comb begin
        if (none_agree) begin
            st_d = VS_SPLIT;
        end else if (|odd) begin
            st_d = VS_MASKED;
        end else begin
            st_d = VS_UNANIMOUS;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= VS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vote_q  <= '0;
            odd_a_q <= 1'b0;
            odd_b_q <= 1'b0;
            odd_c_q <= 1'b0;
            err_q   <= 1'b0;
            split_q <= 1'b0;
        end else begin
            odd_a_q <= odd[0];
            odd_b_q <= odd[1];
            odd_c_q <= odd[2];
            err_q   <= |odd;
            split_q <= none_agree;
            unique case (st_d)
                VS_UNANIMOUS,
                VS_MASKED:    vote_q <= pick;
                VS_SPLIT,
                VS_IDLE:      vote_q <= vote_q;
            endcase
        end
    end

    // R5: a raised flag means the replica differed from both peers one edge earlier
    a_r5_flag_a_cause: assert property (@(posedge clk) disable iff (!rst_n)
        odd_a_q |-> ($past(rep_a) != $past(rep_b)) && ($past(rep_a) != $past(rep_c)));
    a_r5_flag_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
        odd_b_q |-> ($past(rep_b) != $past(rep_a)) && ($past(rep_b) != $past(rep_c)));
    a_r5_flag_c_cause: assert property (@(posedge clk) disable iff (!rst_n)
        odd_c_q |-> ($past(rep_c) != $past(rep_a)) && ($past(rep_c) != $past(rep_b)));

    // R6: no majority keeps the forwarded word and raises every flag
    a_r6_split_holds: assert property (@(posedge clk) disable iff (!rst_n)
        split_q |-> (vote_q == $past(vote_q)));
    a_r6_split_all_flags: assert property (@(posedge clk) disable iff (!rst_n)
        split_q |-> (odd_a_q && odd_b_q && odd_c_q && err_q));

    // R8: with a majority at most one replica is flagged
    a_r8_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !split_q |-> $onehot0({odd_a_q, odd_b_q, odd_c_q}));

    // R7: an error needs some mismatch among the captured triple
    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (($past(rep_a) != $past(rep_b)) || ($past(rep_b) != $past(rep_c))));

    // R3: unanimous capture forwards replica A with no error
    a_r3_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == VS_UNANIMOUS) |-> ((vote_q == $past(rep_a)) && !err_q));

    // R4: masked capture forwards A unless A is the odd one, then B
    a_r4_mask_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == VS_MASKED) |-> (vote_q == (odd_a_q ? $past(rep_b) : $past(rep_a))));

endmodule

// File: tb/tmr_voter_bench.sv
`timescale 1ns/1ps
module tmr_voter_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] rep_a = '0;
    logic [W-1:0] rep_b = '0;
    logic [W-1:0] rep_c = '0;
    logic [W-1:0] vote_q;
    logic         odd_a_q, odd_b_q, odd_c_q, err_q, split_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [W-1:0] exp_vote = '0;

    always #4 clk = ~clk;

    tmr_voter #(.DATA_W(W)) u_tmr_voter (
        .clk     (clk),
        .rst_n   (rst_n),
        .rep_a   (rep_a),
        .rep_b   (rep_b),
        .rep_c   (rep_c),
        .vote_q  (vote_q),
        .odd_a_q (odd_a_q),
        .odd_b_q (odd_b_q),
        .odd_c_q (odd_c_q),
        .err_q   (err_q),
        .split_q (split_q)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_odd(input logic [W-1:0] a, b, c);
        return {(c != a) && (c != b), (b != a) && (b != c), (a != b) && (a != c)};
    endfunction

    // drive at a falling edge, capture at the rising edge, check at the next falling edge
    task automatic step(input logic [W-1:0] a, b, c);
        logic [2:0] eo;
        logic       es;
        string      tag;
        rep_a = a; rep_b = b; rep_c = c;
        #1;
        check("R2", "vote before edge", vote_q, exp_vote);
        eo = ref_odd(a, b, c);
        es = (a != b) && (b != c) && (a != c);
        if (!es) exp_vote = eo[0] ? b : a;
        tag = es ? "R6" : ((|eo) ? "R4" : "R3");
        @(negedge clk);
        check(tag,  "vote",  vote_q, exp_vote);
        check("R5", "flags", {13'd0, odd_c_q, odd_b_q, odd_a_q}, {13'd0, eo});
        check("R7", "err",   {15'd0, err_q},   {15'd0, |eo});
        check(es ? "R6" : "R8", "split", {15'd0, split_q}, {15'd0, es});
    endtask

    function automatic logic [W-1:0] other(input logic [W-1:0] x, y);
        logic [W-1:0] v;
        v = W'($urandom);
        while (v == x || v == y) v = v + 1'b1;
        return v;
    endfunction

    initial begin
        logic [W-1:0] v, u;
        void'($urandom(32'd20240611));
        rep_a = 16'h1111; rep_b = 16'h2222; rep_c = 16'h3333;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check("R1", "vote",  vote_q, '0);
        check("R1", "flags", {13'd0, odd_c_q, odd_b_q, odd_a_q}, '0);
        check("R1", "err/split", {14'd0, err_q, split_q}, '0);
        rst_n = 1'b1;
        // R6: no majority straight after reset keeps zero
        step(16'h1111, 16'h2222, 16'h3333);
        // R3
        step(16'hBEEF, 16'hBEEF, 16'hBEEF);
        // R4: each replica in turn outvoted
        step(16'h0001, 16'h5A5A, 16'h5A5A);
        step(16'h7777, 16'h0002, 16'h7777);
        step(16'hC3C3, 16'hC3C3, 16'h0004);
        // R6: no majority after a valid result holds it
        step(16'hAAAA, 16'h5555, 16'hFFFF);
        step(16'h0000, 16'h0001, 16'h0002);
        // boundary words
        step(16'hFFFF, 16'hFFFF, 16'h0000);
        step(16'h0000, 16'h0000, 16'h0000);
        // random mix
        for (int n = 0; n < 600; n++) begin
            v = W'($urandom);
            case ($urandom % 5)
                0: step(v, v, v);
                1: begin u = other(v, v); step(u, v, v); end
                2: begin u = other(v, v); step(v, u, v); end
                3: begin u = other(v, v); step(v, v, u); end
                default: begin
                    u = other(v, v);
                    step(v, u, other(v, u));
                end
            endcase
            if (n % 97 == 5) step(W'($urandom), W'($urandom), W'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule